// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate frequency. It counts the rising edges of a digitised IF input during a timed gate window. Two values set it up: an enable bit and a two-bit gate-length code. They sit in a small control register, and that register takes new values only when the serial chip-enable line falls. A measurement is armed only when the enable bit goes from 0 to 1 at such a latch event. The block then waits a fixed settling interval so that the IF source can become stable. After that it opens the gate for 4, 8, 32 or 64 ms.

When the gate closes, the block raises a done flag and freezes the count. The count is then read out on one serial pin, most significant bit first, and one bit is advanced for each rising edge of an external read clock. Writing the enable bit as 0 clears the count, the readout register and the done flag, and keeps them cleared. Software must therefore read the result before it disables the counter. A latch event that keeps the enable bit at 1 after the gate has closed reloads the readout register, so the same result can be read again.

Top module: `gated_if_counter`

## Requirements
- R1: The enable bit and the gate code are captured only on a high-to-low transition of `latch_ce`. A high level with `cfg_en`=1 and no falling edge does not start anything.
- R2: A measurement starts only when a latch event changes the enable bit from 0 to 1. A latch event with the enable bit already 1 does not restart a measurement that is waiting or gating.
- R3: `busy` is high during the settling wait and the gate. `done` rises exactly WAIT_CYCLES plus the gate length, in clock cycles, after the clock edge that detects the latch. Gate codes: 0=4 ms, 1=8 ms, 2=32 ms, 3=64 ms, where 1 ms is CLKS_PER_MS cycles.
- R4: IF edges that arrive during the settling wait are not counted.
- R5: During the gate, every rising edge of `if_in` is counted once, after a two-flop synchroniser.
- R6: The count saturates at all ones (2^CNT_W-1) and does not wrap.
- R7: `done` goes high when the gate closes and low when the enable bit is latched as 0. `busy` and `done` are never high together. After reset both are 0.
- R8: While the enable bit is 0, the count and the readout are held at zero, and `sdo` is 0.
- R9: Once the gate has closed, `sdo` presents the result MSB first. Each rising edge of `rd_clk` advances it by one bit. Zeros follow the LSB.
- R10: A latch event with `cfg_en`=1 while the result is held reloads the readout from the held result. It does not start a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; time base for the wait and the gate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| latch_ce | input | 1 | Serial chip-enable; its falling edge latches the control values |
| cfg_en | input | 1 | Enable bit value offered at the latch |
| cfg_gate | input | 2 | Gate-length code offered at the latch |
| if_in | input | 1 | Digitised IF signal |
| rd_clk | input | 1 | Read clock; each rising edge shifts the result one bit |
| busy | output | 1 | Wait or gate in progress |
| done | output | 1 | Gate closed; result held |
| sdo | output | 1 | Serial result, MSB first |

## Verification
The hardest situations to reach are a latch event that arrives in the middle of a running measurement, and IF activity that stops just before the gate opens. In both, the timing of the stimulus relative to the internal phases decides the outcome. The bench counts clock cycles from the latch edge. It issues a second enable-1 latch partway through the wait and checks that `done` still rises at the cycle set by the first latch. It drives IF edges only during the first half of the wait and expects a zero count. The bench chooses IF periods that divide the gate length exactly, so the expected counts do not depend on the phase of the IF signal.

// File: rtl/gic_pkg.sv
package gic_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_GATE, ST_DONE} gic_state_e;

  // gate length in milliseconds for each code
  function automatic int gate_ms(input logic [1:0] code);
    case (code)
      2'd0:    gate_ms = 4;
      2'd1:    gate_ms = 8;
      2'd2:    gate_ms = 32;
      default: gate_ms = 64;
    endcase
  endfunction
endpackage

// File: rtl/gic_sync_edge.sv
module gic_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/gic_sequencer.sv
module gic_sequencer
  import gic_pkg::*;
#(
  parameter int WAIT_CYCLES = 400000,
  parameter int CLKS_PER_MS = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       en_q,
  input  logic [1:0] gate_code,
  output gic_state_e state,
  output logic       close
);
  localparam int TMR_W = $clog2(64 * CLKS_PER_MS + WAIT_CYCLES + 1);

  gic_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    if (arm) begin
      state_d = ST_WAIT;
      tmr_d   = TMR_W'(WAIT_CYCLES - 1);
    end else if (!en_q) begin
      state_d = ST_IDLE;
      tmr_d   = '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (tmr_q == '0) begin
            state_d = ST_GATE;
            tmr_d   = TMR_W'(gate_ms(gate_code) * CLKS_PER_MS - 1);
          end else begin
            tmr_d = tmr_q - 1'b1;
          end
        end
        ST_GATE: begin
          if (tmr_q == '0) state_d = ST_DONE;
          else             tmr_d   = tmr_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state = state_q;
  assign close = (state_q == ST_GATE) && (tmr_q == '0) && en_q && !arm;

  // R3
  done_from_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_DONE) |-> $past(state_q) == ST_GATE);
  // R2
  wait_only_by_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && tmr_q == TMR_W'(WAIT_CYCLES - 1)) |-> $past(arm));
endmodule

// File: rtl/gic_counter.sv
module gic_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             pulse,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                     cnt_d = '0;
    else if (cnt_en && pulse && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/gic_shifter.sv
module gic_shifter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  input  logic             shift,
  output logic             sdo
);
  logic [CNT_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr)        sh_d = '0;
    else if (load)  sh_d = din;
    else if (shift) sh_d = {sh_q[CNT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sdo = sh_q[CNT_W-1];

  // R8
  clr_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sdo);
  // R9
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> sdo == $past(din[CNT_W-1]));
endmodule

// File: rtl/gated_if_counter.sv
module gated_if_counter
  import gic_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int CLKS_PER_MS = 100000,
  parameter int WAIT_CYCLES = 4 * CLKS_PER_MS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_ce,
  input  logic       cfg_en,
  input  logic [1:0] cfg_gate,
  input  logic       if_in,
  input  logic       rd_clk,
  output logic       busy,
  output logic       done,
  output logic       sdo
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // control register, loaded on falling chip-enable
  logic       ce_q;
  logic       en_q, en_d;
  logic [1:0] gate_q, gate_d;
  logic       latch_ev, arm, reload, close;
  logic       load_q, load_d;
  gic_state_e state;

  assign latch_ev = ce_q & ~latch_ce;
  assign arm      = latch_ev & cfg_en & ~en_q;
  assign reload   = latch_ev & cfg_en & en_q & (state == ST_DONE);

  always_comb begin
    en_d   = en_q;
    gate_d = gate_q;
    if (latch_ev) begin
      en_d   = cfg_en;
      gate_d = cfg_gate;
    end
    load_d = close | reload;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ce_q   <= 1'b0;
      en_q   <= 1'b0;
      gate_q <= 2'b00;
      load_q <= 1'b0;
    end else begin
      ce_q   <= latch_ce;
      en_q   <= en_d;
      gate_q <= gate_d;
      load_q <= load_d;
    end
  end

  logic             if_rise, rd_rise;
  logic [CNT_W-1:0] cnt;
  logic             clr;

  assign clr = arm | ~en_q;

  gic_sync_edge #(.STAGES(2)) u_if_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(if_in), .rise(if_rise));

  gic_sync_edge #(.STAGES(2)) u_rd_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(rd_clk), .rise(rd_rise));

  gic_sequencer #(.WAIT_CYCLES(WAIT_CYCLES), .CLKS_PER_MS(CLKS_PER_MS)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .arm(arm), .en_q(en_q),
    .gate_code(gate_q), .state(state), .close(close));

  gic_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr(clr),
    .cnt_en(state == ST_GATE), .pulse(if_rise), .cnt(cnt));

  gic_shifter #(.CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .load(load_q && !clr),
    .din(cnt), .shift(rd_rise && state == ST_DONE), .sdo(sdo));

  assign busy = (state == ST_WAIT) || (state == ST_GATE);
  assign done = (state == ST_DONE);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(busy && done));
  // R8
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_q |=> (cnt == '0 && !done));
  // R1
  ctl_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(ce_q && !latch_ce) |=> ($stable(en_q) && $stable(gate_q)));
endmodule

// File: tb/test_gated_if_counter.sv
module test_gated_if_counter;
  localparam int CNT_W = 9;
  localparam int CPM   = 20;
  localparam int WAITC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       latch_ce = 1'b0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_gate = 2'd0;
  logic       if_in = 1'b0;
  logic       rd_clk = 1'b0;
  logic       busy, done, sdo;

  int errors = 0;
  int checks = 0;
  int if_half = 0;
  int exp_q[$];
  event ev_read, ev_read_done;

  always #5 clk = ~clk;

  gated_if_counter #(.CNT_W(CNT_W), .CLKS_PER_MS(CPM), .WAIT_CYCLES(WAITC)) i_gated_if_counter (
    .clk(clk), .rst_n(rst_n), .latch_ce(latch_ce), .cfg_en(cfg_en),
    .cfg_gate(cfg_gate), .if_in(if_in), .rd_clk(rd_clk),
    .busy(busy), .done(done), .sdo(sdo));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // IF stimulus generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (if_half == 0) begin
        if_in = 1'b0; ph = 0;
      end else begin
        ph++;
        if (ph >= if_half) begin ph = 0; if_in = ~if_in; end
      end
    end
  end

  // monitor: serial readout compared against the scoreboard queue
  initial begin
    forever begin
      int got;
      int exp;
      @(ev_read);
      repeat (3) @(negedge clk);
      got = 0;
      for (int i = 0; i < CNT_W; i++) begin
        got = (got << 1) | int'(sdo);
        rd_clk = 1'b1;
        repeat (4) @(negedge clk);
        rd_clk = 1'b0;
        repeat (4) @(negedge clk);
      end
      exp = exp_q.pop_front();
      check(got == exp, "R9 serial result", got, exp);
      check(sdo == 1'b0, "R9 zero after LSB", int'(sdo), 0);
      -> ev_read_done;
    end
  end

  task automatic do_latch(input bit e, input logic [1:0] g);
    @(negedge clk);
    cfg_en = e; cfg_gate = g; latch_ce = 1'b1;
    @(negedge clk);
    latch_ce = 1'b0;
  endtask

  task automatic read_expect(input int exp);
    exp_q.push_back(exp);
    -> ev_read;
    @(ev_read_done);
  endtask

  function automatic int gate_cycles(input int code);
    case (code)
      0: return 4 * CPM;
      1: return 8 * CPM;
      2: return 32 * CPM;
      default: return 64 * CPM;
    endcase
  endfunction

  task automatic measure(input int code, input int half, input int exp_cnt, input string tag);
    int j;
    do_latch(1'b0, 2'd0);
    if_half = half;
    do_latch(1'b1, code[1:0]);
    @(negedge clk);
    check(busy == 1'b1, "R3 busy after arm", int'(busy), 1);
    j = 0;
    while (!done && j < 5000) begin
      @(negedge clk);
      j++;
    end
    check(j == WAITC + gate_cycles(code), "R3 wait+gate length", j, WAITC + gate_cycles(code));
    if_half = 0;
    read_expect(exp_cnt);
    $display("measure %s code=%0d done", tag, code);
  endtask

  initial begin
    int j;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !sdo, "R7 reset state", int'({busy, done, sdo}), 0);

    // R1: high level without a fall does nothing
    cfg_en = 1'b1; latch_ce = 1'b1;
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R1 no latch without fall", int'(busy), 0);
    latch_ce = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R1 latch on fall", int'(busy), 1);

    // R5 / R3: exact counts for each gate code
    measure(0, 2, 20, "R5 4ms");
    measure(1, 4, 20, "R5 8ms");
    measure(2, 2, 160, "R5 32ms");
    // R6: 640 edges saturate a 9-bit count
    measure(3, 1, 511, "R6 saturate");

    // R4: IF only during the first half of the wait
    do_latch(1'b0, 2'd0);
    if_half = 2;
    do_latch(1'b1, 2'd0);
    repeat (20) @(negedge clk);
    if_half = 0;
    wait (done);
    read_expect(0);

    // R10: reread after a relatch with enable kept at 1
    measure(0, 2, 20, "R10 base");
    do_latch(1'b1, 2'd3);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b1, "R2 no restart when held", int'({busy, done}), 1);
    read_expect(20);

    // R8 / R7: disable clears everything
    do_latch(1'b0, 2'd0);
    repeat (2) @(negedge clk);
    check(!done && !busy, "R7 done cleared by disable", int'({busy, done}), 0);
    check(sdo == 1'b0, "R8 sdo cleared", int'(sdo), 0);
    read_expect(0);

    // R2: second enable latch during the wait does not restart
    do_latch(1'b1, 2'd0);
    @(negedge clk);
    j = 0;
    repeat (30) begin @(negedge clk); j++; end
    cfg_en = 1'b1; latch_ce = 1'b1;
    @(negedge clk); j++;
    latch_ce = 1'b0;
    while (!done && j < 5000) begin @(negedge clk); j++; end
    check(j == WAITC + 4 * CPM, "R2 relatch keeps timing", j, WAITC + 4 * CPM);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule